// File: doc/BRIEF.md
# Prescaled Fractional Baud Tick Generator

This block turns a fast system clock into the two timing strobes that serial transmit and receive logic needs: an oversample strobe and a one-per-bit strobe. The clock is first divided by a programmable prescale value. The slower tick stream then feeds a divisor that has a whole part and a four-bit fractional part in sixteenths. The fractional part is handled by a small accumulator that stretches some oversample periods by one prescaled tick, so the long-run rate comes close to a non-integer ratio. A final counter collects either 8 or 16 oversample strobes per bit, chosen at run time.

Software works out the prescale, whole and fractional values for the wanted line rate. One example is a 12 MHz clock at 115200 bps with 16x oversampling: prescale 1, whole 6, fraction 8, which gives 6.5 against an ideal 6.51. A 16 MHz clock at 9600 bps becomes whole 104, a small known error against 104.17. An 80 MHz clock can be prescaled by 8 to 10 MHz and then divided by 65 and 2/16. The values are presented on the configuration inputs with a one-cycle write strobe. A small control state machine has two states. ST_IDLE holds every counter at zero while the enable is low. ST_RUN lets the counters run. The IDLE-to-RUN transition is taken when the enable is sampled high, and RUN-to-IDLE when it is sampled low. A configuration write seen in ST_RUN keeps the state but restarts all counters.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is active and in the first cycles after it, with the enable low, both strobes are low.
- R2: With fraction 0, os_tick pulses once every P×D clock cycles, where P is the prescale value and D is the whole divisor. A prescale value of 0 bypasses the prescaler and acts as P = 1.
- R3: With a non-zero fraction F, the period that starts with accumulator value A lasts P×(D+1) cycles when A+F is 16 or more, and P×D cycles otherwise. At the end of each period the accumulator becomes (A+F) mod 16. It starts at 0.
- R4: A whole divisor of 0 or 1 divides by 1.
- R5: bit_tick is high on every 16th os_tick after a restart when cfg_os16 is 1, and on every 8th when it is 0. It is never high on two consecutive cycles.
- R6: bit_tick is high only in a cycle in which os_tick is also high.
- R7: A configuration write, sampled at edge E, loads all fields and restarts every counter and the accumulator. Both strobes are low in the cycle after E, and the first os_tick appears exactly P×D cycles after E.
- R8: When the enable is sampled low, both strobes are low from the next cycle on and stay low. When the enable is sampled high again at edge E, the first os_tick appears P×D cycles after E.
- R9: Over many periods the average os_tick spacing equals P×(D+F/16) clock cycles to within one cycle, for standard-rate settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds all counters at zero |
| cfg_we | input | 1 | One-cycle write strobe for all configuration fields |
| cfg_presc | input | PRESC_W (8) | Prescale value; 0 and 1 both bypass |
| cfg_int | input | INT_W (12) | Whole part of the divisor; 0 and 1 both divide by 1 |
| cfg_frac | input | FRAC_W (4) | Fractional part of the divisor, in sixteenths |
| cfg_os16 | input | 1 | 1 selects 16 oversamples per bit, 0 selects 8 |
| os_tick | output | 1 | Oversample strobe, one clock cycle wide |
| bit_tick | output | 1 | Bit strobe, one clock cycle wide, aligned to an os_tick |

## Verification
The bench targets the fractional stretch sequence. If the carry test were wrong, or the accumulator updated at the wrong moment, ticks would land one prescaled tick early or late, and the long-run average would drift by whole cycles. Divide-by-one cases (prescale 0, divisor 0) show whether the bypass paths or the zero decodes are broken: a bad decode produces a period of 256 or 4096 instead of 1. Restarts by configuration write in mid-period, and by re-enable, check that the first tick comes exactly one full period later: a design that kept its old count would tick early, and one that missed the clear would be off by a cycle. Switching between 8x and 16x checks that bit strobes fall on the right oversample index.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bdg_state_e;

    localparam int unsigned OS_LO = 8;
    localparam int unsigned OS_HI = 16;

endpackage

// File: rtl/bdg_prescale.sv
module bdg_prescale #(
    parameter int unsigned PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               pre_tick
);

    logic [PRESC_W-1:0] cnt_q;
    logic               at_end;

    // Values 0 and 1 both give a tick on every cycle.
    always_comb begin
        if (presc <= PRESC_W'(1)) begin
            at_end = (cnt_q == '0);
        end else begin
            at_end = (cnt_q == presc - PRESC_W'(1));
        end
        pre_tick = run && at_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRESC_W'(1);
        end
    end

endmodule

// File: rtl/bdg_fracdiv.sv
module bdg_fracdiv #(
    parameter int unsigned INT_W  = 12,
    parameter int unsigned FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              pre_tick,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              os_fire
);

    localparam int unsigned CNT_W = INT_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic              stretch;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  limit;

    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, div_frac};
        stretch = acc_sum[FRAC_W];
        if (div_int <= INT_W'(1)) begin
            base = CNT_W'(1);
        end else begin
            base = {1'b0, div_int};
        end
        limit   = base + CNT_W'(stretch);
        os_fire = pre_tick && (cnt_q == limit - CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (os_fire) begin
            cnt_q <= '0;
            acc_q <= acc_sum[FRAC_W-1:0];
        end else if (pre_tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/bdg_oscount.sv
module bdg_oscount
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic os_fire,
    input  logic os16,
    output logic bit_fire
);

    localparam int unsigned OC_W = $clog2(OS_HI);

    logic [OC_W-1:0] cnt_q;
    logic            at_end;

    always_comb begin
        if (os16) begin
            at_end = (cnt_q == OC_W'(OS_HI - 1));
        end else begin
            at_end = (cnt_q == OC_W'(OS_LO - 1));
        end
        bit_fire = os_fire && at_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (os_fire) begin
            cnt_q <= at_end ? '0 : cnt_q + OC_W'(1);
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int unsigned PRESC_W = 8,
    parameter int unsigned INT_W   = 12,
    parameter int unsigned FRAC_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               cfg_we,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [INT_W-1:0]   cfg_int,
    input  logic [FRAC_W-1:0]  cfg_frac,
    input  logic               cfg_os16,
    output logic               os_tick,
    output logic               bit_tick
);

    bdg_state_e         state_q;
    bdg_state_e         state_d;
    logic               run;

    logic [PRESC_W-1:0] presc_q;
    logic [INT_W-1:0]   int_q;
    logic [FRAC_W-1:0]  frac_q;
    logic               os16_q;

    logic               pre_tick;
    logic               os_fire;
    logic               bit_fire;
    logic               os_q;
    logic               bit_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and run control.
    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end
                run = en && !cfg_we;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Configuration holding registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            int_q   <= '0;
            frac_q  <= '0;
            os16_q  <= 1'b1;
        end else if (cfg_we) begin
            presc_q <= cfg_presc;
            int_q   <= cfg_int;
            frac_q  <= cfg_frac;
            os16_q  <= cfg_os16;
        end
    end

    bdg_prescale #(
        .PRESC_W (PRESC_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .presc    (presc_q),
        .pre_tick (pre_tick)
    );

    bdg_fracdiv #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .pre_tick (pre_tick),
        .div_int  (int_q),
        .div_frac (frac_q),
        .os_fire  (os_fire)
    );

    bdg_oscount u_osc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .os_fire  (os_fire),
        .os16     (os16_q),
        .bit_fire (bit_fire)
    );

    // Registered strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q  <= 1'b0;
            bit_q <= 1'b0;
        end else if (!run) begin
            os_q  <= 1'b0;
            bit_q <= 1'b0;
        end else begin
            os_q  <= os_fire;
            bit_q <= bit_fire;
        end
    end

    assign os_tick  = os_q;
    assign bit_tick = bit_q;

endmodule

// File: rtl/bdg_chk.sv
module bdg_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cfg_we,
    input logic os_tick,
    input logic bit_tick
);

    a_r6_bit_with_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    a_r5_bit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!os_tick && !bit_tick));

    a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!os_tick && !bit_tick));

    // R1: strobes low while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_low: assert (!os_tick && !bit_tick);
        end
    end

endmodule

bind baud_tick_gen bdg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cfg_we   (cfg_we),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_presc = '0;
    logic [11:0] cfg_int = '0;
    logic [3:0]  cfg_frac = '0;
    logic        cfg_os16 = 1'b1;
    logic        os_tick;
    logic        bit_tick;

    always #2 clk = ~clk;

    baud_tick_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cfg_we    (cfg_we),
        .cfg_presc (cfg_presc),
        .cfg_int   (cfg_int),
        .cfg_frac  (cfg_frac),
        .cfg_os16  (cfg_os16),
        .os_tick   (os_tick),
        .bit_tick  (bit_tick)
    );

    typedef struct {
        int    t;
        bit    b;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    armed = 1'b0;
    int    got = 0;
    int    last_t = 0;
    int    base = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // Monitor: pops one expected strobe per observed oversample strobe.
    always @(negedge clk) begin
        if (armed && (os_tick || bit_tick)) begin
            if (q.size() == 0) begin
                check(1'b0, "R8 unexpected strobe", int'(os_tick), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(os_tick == 1'b1, "R6 bit without os", int'(os_tick), 1);
                check(cyc == e.t, e.tag, cyc - base, e.t - base);
                check(bit_tick == e.b, "R5 bit strobe index", int'(bit_tick), int'(e.b));
                got++;
                last_t = cyc;
            end
        end
    end

    // Driver: builds the expected tick schedule from the requirements.
    task automatic arm_and_wait(input int p, input int d, input int f,
                                input bit s16, input int k, input string tag);
        int pe;
        int de;
        int acc;
        int t;
        int os;
        int ideal16;
        int meas16;
        int diff;
        pe  = (p < 1) ? 1 : p;
        de  = (d < 1) ? 1 : d;
        os  = s16 ? 16 : 8;
        acc = 0;
        t   = 0;
        q.delete();
        base = cyc;
        for (int i = 0; i < k; i++) begin
            int st;
            st  = ((acc + f) >= 16) ? 1 : 0;
            t   = t + pe * (de + st);
            acc = (acc + f) % 16;
            q.push_back('{base + t, (((i + 1) % os) == 0), (i == 0) ? "R7 first tick after restart" : tag});
        end
        got   = 0;
        armed = 1'b1;
        wait (cyc >= base + t + 1);
        #1;
        armed = 1'b0;
        check(got == k, "R9 tick count", got, k);
        ideal16 = k * pe * (16 * de + f);
        meas16  = 16 * (last_t - base);
        diff    = meas16 - ideal16;
        if (diff < 0) diff = -diff;
        check(diff <= 16 * k, "R9 long-run average", meas16, ideal16);
    endtask

    task automatic run_cfg(input int p, input int d, input int f,
                           input bit s16, input int k, input string tag);
        @(negedge clk);
        armed     = 1'b0;
        cfg_presc = 8'(p);
        cfg_int   = 12'(d);
        cfg_frac  = 4'(f);
        cfg_os16  = s16;
        cfg_we    = 1'b1;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        arm_and_wait(p, d, f, s16, k, tag);
    endtask

    initial begin : watchdog
        #(4 * 190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk) begin
            check(!os_tick && !bit_tick, "R1 strobes in reset", int'(os_tick | bit_tick), 0);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk) begin
            check(!os_tick && !bit_tick, "R1 strobes after reset", int'(os_tick | bit_tick), 0);
        end
        @(negedge clk);
        en = 1'b1;
        // 12 MHz clock, 115200 bps, 16x: 6 + 8/16
        run_cfg(1, 6, 8, 1'b1, 40, "R3 fractional 6.5");
        // 16 MHz clock, 9600 bps, 16x: whole 104, prescaler bypassed by 0
        run_cfg(0, 104, 0, 1'b1, 20, "R2 integer 104");
        // 80 MHz prescaled by 8, 9600 bps, 16x: 65 + 2/16
        run_cfg(8, 65, 2, 1'b1, 20, "R3 prescaled 65.125");
        // divide-by-one paths, 8x
        run_cfg(0, 0, 0, 1'b0, 24, "R4 divisor 0 bypass");
        run_cfg(1, 1, 0, 1'b1, 34, "R4 divisor 1");
        // high fraction, short whole, 8x
        run_cfg(3, 1, 15, 1'b0, 33, "R3 fraction 15");
        // 12 MHz clock, 1200 bps, 8x: prescale 10, whole 125
        run_cfg(10, 125, 0, 1'b0, 17, "R2 prescaled 1250");
        // 12 MHz, 19200 bps, 16x: 39 + 1/16
        run_cfg(1, 39, 1, 1'b1, 36, "R3 fraction 1");

        // Disable: no strobes while en is low.
        run_cfg(2, 7, 5, 1'b1, 3, "R3 before disable");
        @(negedge clk);
        en = 1'b0;
        @(posedge clk);
        #1;
        q.delete();
        got   = 0;
        armed = 1'b1;
        repeat (60) @(posedge clk);
        #1;
        armed = 1'b0;
        check(got == 0, "R8 quiet while disabled", got, 0);
        // Re-enable restarts with the held configuration.
        @(negedge clk);
        en = 1'b1;
        @(posedge clk);
        #1;
        arm_and_wait(2, 7, 5, 1'b1, 20, "R8 after re-enable");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule